// File: doc/BRIEF.md
# Bootstrap Charge and Fault-Clear Sequencer

This block runs on the controller side of a three-phase inverter that also has a brake leg, and it brings the power stage out of power-up. Once it is started, it sends a burst of short on-pulses to the three lower-leg switches together, which charges the floating supplies of the upper-leg drivers. After the burst it clears any latched fault in the power stage. It does this by commanding each switch group on once, in a fixed order: the brake first, then the three lower legs, then the three upper legs. At the end it raises a done flag, and the normal PWM source takes over the gate commands from that point.

The power stage is allowed to report a fault while the first lower-leg pulses are applied, so the fault input is ignored during charging and during clearing. The fault input is examined at one moment only, the last cycle of the final off step. If the fault is still active then, the sequencer stops in an error state and does not report done. All command outputs are active low and rest high, which means off. Pulse width and pulse count are set in clock cycles. At a 50 MHz clock, the default width of 1000 cycles gives a pulse of about 20 µs. The pulse count should be set between 10 and 500 to match the size of the bootstrap capacitor.

Top module: `bcs_seq`

## Requirements
- R1: After reset, and whenever the block is idle, every command output (`brk_n_o`, `lo_n_o`, `hi_n_o`) is 1, and `done_o` and `err_o` are 0.
- R2: When `start_i` is sampled at 1 on a clock edge in idle, all three bits of `lo_n_o` go to 0 together in the cycle that follows. Through the whole charging burst, `brk_n_o` and `hi_n_o` stay 1.
- R3: Each charging pulse holds `lo_n_o` at 3'b000 for exactly PULSE_W cycles, followed by 3'b111 for exactly PULSE_W cycles.
- R4: The burst contains exactly NUM_PULSES charging pulses.
- R5: The value of `fault_i` during charging and during clearing changes neither the command outputs nor the timing.
- R6: After the burst, clearing runs in this order: `brk_n_o` is 0 for PULSE_W cycles and then off for PULSE_W cycles; next `lo_n_o` is 3'b000 for PULSE_W cycles and then off for PULSE_W cycles; last `hi_n_o` is 3'b000 for PULSE_W cycles and then off for PULSE_W cycles. Only one group is on at any time.
- R7: If `fault_i` is 1 in the last cycle of the upper-leg off step, `err_o` goes to 1 in the next cycle, and `done_o` stays 0.
- R8: Otherwise `done_o` goes to 1 in that next cycle, which is cycle 2·PULSE_W·NUM_PULSES + 6·PULSE_W counted from the first charging cycle. All command outputs stay 1 from then on.
- R9: In any state, bit i of `lo_n_o` and bit i of `hi_n_o` are never 0 at the same time (bit 0 is phase U, bit 1 is V, bit 2 is W).
- R10: `start_i` has no effect while a sequence is running and after done or error has been reached.
- R11: `done_o` and `err_o` are never both 1. Each one stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts the sequence when sampled at 1 in idle |
| fault_i | input | 1 | Fault report from the power stage, 1 = fault |
| brk_n_o | output | 1 | Brake switch command, active low |
| lo_n_o | output | 3 | Lower-leg commands for U/V/W (bits 0/1/2), active low |
| hi_n_o | output | 3 | Upper-leg commands for U/V/W (bits 0/1/2), active low |
| done_o | output | 1 | Sequence finished cleanly; PWM may take over |
| err_o | output | 1 | Fault was still present at the end of clearing |

## Verification
The bench builds the block with PULSE_W = 3 and NUM_PULSES = 4, so one full run takes 42 cycles. With these values, every pulse edge, the change from the burst to the brake step, and the fault decision at the end can all be checked cycle by cycle in a short run. The odd pulse width exercises the wrap of the phase timer away from a power of two. The small count allows the last burst pulse and the pulse counter's terminal value to be checked directly. The default values (about 20 µs pulses and 64 of them) only lengthen each phase and do not change the order of the steps.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHG_ON, ST_CHG_OFF,
    ST_BRK_ON, ST_BRK_OFF, ST_LO_ON, ST_LO_OFF,
    ST_HI_ON, ST_HI_OFF, ST_DONE, ST_ERR
  } seq_st_e;

  typedef struct packed {
    logic       brk_n;
    logic [2:0] lo_n;
    logic [2:0] hi_n;
  } cmd_t;

  localparam cmd_t CMD_ALL_OFF = '{brk_n: 1'b1, lo_n: 3'b111, hi_n: 3'b111};

  // Returns 1 in the final cycle of a window that is lim cycles long.
  function automatic logic at_limit(input int unsigned cnt, input int unsigned lim);
    return cnt == (lim - 1);
  endfunction

  // The phase timer runs only while the block drives pulses.
  function automatic logic is_busy(input seq_st_e s);
    return (s != ST_IDLE) && (s != ST_DONE) && (s != ST_ERR);
  endfunction

  // Maps each state to its command pattern; only one group is on at a time.
  function automatic cmd_t cmd_of_state(input seq_st_e s);
    cmd_t c;
    c = CMD_ALL_OFF;
    case (s)
      ST_CHG_ON, ST_LO_ON: c.lo_n  = 3'b000;
      ST_BRK_ON:           c.brk_n = 1'b0;
      ST_HI_ON:            c.hi_n  = 3'b000;
      default:             c       = CMD_ALL_OFF;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/bcs_phase_timer.sv
module bcs_phase_timer #(
  parameter int unsigned PULSE_W = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  import bcs_pkg::*;

  localparam int unsigned TW = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;

  logic [TW-1:0] cnt_q;

  assign last_o = run_i && at_limit(32'(cnt_q), PULSE_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (last_o)     cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bcs_burst_cnt.sv
module bcs_burst_cnt #(
  parameter int unsigned NUM_PULSES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic charging_i,
  input  logic pulse_end_i,
  output logic final_o
);
  import bcs_pkg::*;

  localparam int unsigned BW = (NUM_PULSES > 1) ? $clog2(NUM_PULSES) : 1;

  logic [BW-1:0] cnt_q;

  assign final_o = at_limit(32'(cnt_q), NUM_PULSES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (!charging_i)         cnt_q <= '0;
    else if (pulse_end_i && !final_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bcs_cmd_drive.sv
module bcs_cmd_drive (
  input  bcs_pkg::seq_st_e state_i,
  output logic             brk_n_o,
  output logic [2:0]       lo_n_o,
  output logic [2:0]       hi_n_o
);
  import bcs_pkg::*;

  cmd_t cmd;

  always_comb begin
    cmd     = cmd_of_state(state_i);
    brk_n_o = cmd.brk_n;
    lo_n_o  = cmd.lo_n;
    hi_n_o  = cmd.hi_n;
  end
endmodule

// File: rtl/bcs_seq.sv
module bcs_seq #(
  parameter int unsigned PULSE_W    = 1000,
  parameter int unsigned NUM_PULSES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       fault_i,
  output logic       brk_n_o,
  output logic [2:0] lo_n_o,
  output logic [2:0] hi_n_o,
  output logic       done_o,
  output logic       err_o
);
  import bcs_pkg::*;

  seq_st_e state_q, state_d;

  // Internal events, named for the checker.
  logic busy;
  logic charging;
  logic phase_last;
  logic burst_last;
  logic pulse_end;

  assign busy      = is_busy(state_q);
  assign charging  = (state_q == ST_CHG_ON) || (state_q == ST_CHG_OFF);
  assign pulse_end = (state_q == ST_CHG_OFF) && phase_last;

  bcs_phase_timer #(.PULSE_W(PULSE_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .last_o (phase_last)
  );

  bcs_burst_cnt #(.NUM_PULSES(NUM_PULSES)) u_burst (
    .clk         (clk),
    .rst_n       (rst_n),
    .charging_i  (charging),
    .pulse_end_i (pulse_end),
    .final_o     (burst_last)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_CHG_ON;
      ST_CHG_ON:  if (phase_last) state_d = ST_CHG_OFF;
      ST_CHG_OFF: if (phase_last) state_d = burst_last ? ST_BRK_ON : ST_CHG_ON;
      ST_BRK_ON:  if (phase_last) state_d = ST_BRK_OFF;
      ST_BRK_OFF: if (phase_last) state_d = ST_LO_ON;
      ST_LO_ON:   if (phase_last) state_d = ST_LO_OFF;
      ST_LO_OFF:  if (phase_last) state_d = ST_HI_ON;
      ST_HI_ON:   if (phase_last) state_d = ST_HI_OFF;
      ST_HI_OFF:  if (phase_last) state_d = fault_i ? ST_ERR : ST_DONE;
      ST_DONE:    state_d = ST_DONE;
      ST_ERR:     state_d = ST_ERR;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  bcs_cmd_drive u_drive (
    .state_i (state_q),
    .brk_n_o (brk_n_o),
    .lo_n_o  (lo_n_o),
    .hi_n_o  (hi_n_o)
  );

  assign done_o = (state_q == ST_DONE);
  assign err_o  = (state_q == ST_ERR);
endmodule

// File: rtl/bcs_seq_chk.sv
module bcs_seq_chk #(
  parameter int unsigned PULSE_W = 1000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       fault_i,
  input logic       brk_n_o,
  input logic [2:0] lo_n_o,
  input logic [2:0] hi_n_o,
  input logic       done_o,
  input logic       err_o,
  input logic       phase_last
);
  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run <= 0;
    else if (!lo_n_o[0]) low_run <= low_run + 1;
    else                 low_run <= 0;
  end

  assert_no_shoot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (~lo_n_o & ~hi_n_o) == 3'b000);

  assert_lower_together_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_n_o == 3'b000) || (lo_n_o == 3'b111));

  assert_one_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~brk_n_o, lo_n_o == 3'b000, hi_n_o == 3'b000}) <= 1);

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_n_o[0]) |-> (low_run == PULSE_W));

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> ($past(fault_i) && $past(phase_last)));

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> (brk_n_o && lo_n_o == 3'b111 && hi_n_o == 3'b111));
endmodule

bind bcs_seq bcs_seq_chk #(.PULSE_W(PULSE_W)) u_bcs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fault_i    (fault_i),
  .brk_n_o    (brk_n_o),
  .lo_n_o     (lo_n_o),
  .hi_n_o     (hi_n_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .phase_last (phase_last)
);

// File: tb/test_bcs_seq.sv
module test_bcs_seq;
  localparam int W = 3;
  localparam int N = 4;
  localparam int SEQ_LEN = 2*W*N + 6*W;

  // Scenario bits: [3] fault while charging, [2] fault while clearing,
  // [1] fault in final off step, [0] extra start pulse mid-run.
  localparam logic [3:0] SCN [0:5] = '{4'b0000, 4'b1000, 4'b0100,
                                      4'b0010, 4'b1111, 4'b0001};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       fault_i = 1'b0;
  logic       brk_n_o, done_o, err_o;
  logic [2:0] lo_n_o, hi_n_o;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  bcs_seq #(.PULSE_W(W), .NUM_PULSES(N)) i_bcs_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fault_i(fault_i),
    .brk_n_o(brk_n_o), .lo_n_o(lo_n_o), .hi_n_o(hi_n_o),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected {brk, hi[2:0], lo[2:0]} in cycle c after the start edge.
  function automatic logic [6:0] expect_cmd(input int c);
    int seg = c / W;
    if (c >= SEQ_LEN) return 7'h7f;
    if (seg < 2*N) return (seg % 2 == 0) ? 7'b1111000 : 7'h7f;
    case (seg - 2*N)
      0: return 7'b0111111;
      2: return 7'b1111000;
      4: return 7'b1000111;
      default: return 7'h7f;
    endcase
  endfunction

  function automatic string req_of(input int c);
    if (c / W < 2*N) return "R3";
    return "R6";
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; start_i = 1'b0; fault_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_scenario(input logic [3:0] s);
    int falls = 0;
    logic prev_lo = 1'b1;
    start_i = 1'b1;
    @(posedge clk);
    for (int c = 0; c <= SEQ_LEN; c++) begin
      int seg;
      @(negedge clk);
      seg = c / W;
      start_i = (s[0] && c == 5) ? 1'b1 : 1'b0;  // R10 mid-run start
      if (seg < 2*N)            fault_i = s[3];   // R5
      else if (seg < 2*N + 5)   fault_i = s[2];   // R5
      else                      fault_i = s[1];
      if (c < SEQ_LEN) begin
        check({brk_n_o, hi_n_o, lo_n_o} === expect_cmd(c), req_of(c),
              {25'd0, brk_n_o, hi_n_o, lo_n_o}, {25'd0, expect_cmd(c)});
        check(~done_o && ~err_o, "R11 busy", {done_o, err_o}, 0);
        if (prev_lo && !lo_n_o[0] && seg < 2*N) falls++;
        prev_lo = lo_n_o[0];
      end else begin
        check(falls == N, "R4", falls, N);
        check(err_o === s[1], "R7", err_o, s[1]);
        check(done_o === ~s[1], "R8", done_o, ~s[1]);
        check({brk_n_o, hi_n_o, lo_n_o} === 7'h7f, "R8 idle cmds",
              {brk_n_o, hi_n_o, lo_n_o}, 7'h7f);
      end
    end
    fault_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check({brk_n_o, hi_n_o, lo_n_o, done_o, err_o} === 9'b111111100, "R1",
          {brk_n_o, hi_n_o, lo_n_o, done_o, err_o}, 9'b111111100);
    // R1 idle holds without start, even with a fault present
    fault_i = 1'b1;
    repeat (4) @(negedge clk);
    check({brk_n_o, hi_n_o, lo_n_o} === 7'h7f, "R1 idle",
          {brk_n_o, hi_n_o, lo_n_o}, 7'h7f);
    fault_i = 1'b0;

    // R2..R8 scenario table
    for (int i = 0; i < 6; i++) begin
      do_reset();
      run_scenario(SCN[i]);
    end

    // R10/R11: start after done is ignored and done stays
    do_reset();
    run_scenario(4'b0000);
    start_i = 1'b1;
    repeat (3) @(negedge clk);
    start_i = 1'b0;
    repeat (W) @(negedge clk);
    check(lo_n_o === 3'b111, "R10 after done", lo_n_o, 3'b111);
    check(done_o && !err_o, "R11 done sticky", {done_o, err_o}, 2'b10);

    // R11: error is sticky, start ignored
    do_reset();
    run_scenario(4'b0010);
    start_i = 1'b1;
    repeat (2*W) @(negedge clk);
    start_i = 1'b0;
    check(err_o && !done_o, "R11 err sticky", {done_o, err_o}, 2'b01);
    check(lo_n_o === 3'b111, "R10 after err", lo_n_o, 3'b111);

    // R1: reset in mid-burst returns to idle
    start_i = 1'b1;
    do_reset();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    check(lo_n_o === 3'b000, "R2 start", lo_n_o, 3'b000);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({lo_n_o, done_o, err_o} === 5'b11100, "R1 mid reset",
          {lo_n_o, done_o, err_o}, 5'b11100);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule